// File: doc/BRIEF.md
# Three-Wire Real-Time-Clock Serial Slave

This block is the serial side of a real-time clock that a processor reaches by toggling three general-purpose pins in software. Each pin write presents a new 4-bit pin value. Bit 0 of that value is the serial clock, bit 1 is the serial data line and bit 2 is the chip select. The block compares each new value with the value it stored last time. From that comparison it finds the start of a transaction and the rising edges of the serial clock.

After a start, the block shifts in an 8-bit command. The command then either shifts further bytes into a register or shifts register bytes back out. During a read, the block replaces the data bit of the stored pin value on each rising clock edge, so software sees the outgoing bit when it reads the pins. The block holds an 8-bit control register and seven BCD calendar/time bytes. A separate strobe loads the calendar/time bytes from an external timekeeping source. One command asks for an interrupt, which the block gives as a single-cycle pulse.

Top module: `rtc_serial_slave`

## Requirements
- R1: Reset state. During and after reset, `pin_q` is 0, `ctrl_q` is 0x00 and `irq_pulse` is 0. The calendar/time bytes reset to BCD year 0x01, month 0x06, day 0x13, weekday 0x03, hour 0x23, minute 0x59, second 0x59.
- R2: A cycle with `pin_we` high stores `pin_wdata` into `pin_q`, which shows it on the next cycle. The one exception is the data bit, bit 1, during a read-state rising edge. Without `pin_we`, `pin_q` holds its value.
- R3: From idle, a transaction starts only when the stored value has clock (bit 0) = 1 and select (bit 2) = 0 and the new value has select = 1. Any other select rise leaves the block idle, and the pins that follow are passed through unchanged.
- R4: Command bits are taken on each rising clock edge, into byte positions 0 to 7 in arrival order. If the high nibble of the collected byte is 0x6, the byte is decoded as it is. Otherwise it is decoded bit-reversed, so a command sent either bit order gives the same result.
- R5: Decode. Command bit 0 = 1 means read and 0 means write. Bits 3:1 select the register: 1 is control (1 byte), 2 is full date-time (7 bytes) and 3 is time only (3 bytes). Any other code returns to idle.
- R6: In a read, each rising clock edge drives the next register bit onto data bit 1 of `pin_q`, least significant bit first. Date-time bytes come in the order year, month, day, weekday, hour, minute, second. Time bytes come in the order hour, minute, second. After the last bit the block is idle, and further edges are passed through unchanged.
- R7: A 1-byte control write replaces bits 6:0 and keeps bit 7. `ctrl_q` changes only in a cycle with `pin_we`.
- R8: Writes to date-time or time take the full byte count on the wire and change no register.
- R9: A write command with register code 0 clears the control register to 0x00, with no interrupt pulse.
- R10: A write command with register code 6 makes `irq_pulse` high for exactly one cycle. The pulse is in the cycle after the pin write that carries the eighth command bit.
- R11: If select falls during command, write or read, the block returns to idle and clears its bit and byte counters. A following transaction then decodes correctly.
- R12: `tod_load` loads the seven bytes from `tod_in`, byte k from bits 8k+7:8k, in the R6 date-time order. Each byte is masked to its field width: year 8, month 5, day 6, weekday 3, hour 6, minute 7, second 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_we | input | 1 | New pin value present on `pin_wdata` this cycle |
| pin_wdata | input | 4 | Pin value written by the host: clock bit 0, data bit 1, select bit 2 |
| pin_q | output | 4 | Stored pin value, carrying outgoing read bits on bit 1 |
| tod_load | input | 1 | Strobe to load calendar/time bytes |
| tod_in | input | 56 | Seven BCD bytes, year in the low byte through second in the high byte |
| ctrl_q | output | 8 | Control register: bit 3 periodic interrupt enable, bit 6 12-hour mode, bit 7 power-loss flag |
| irq_pulse | output | 1 | Single-cycle interrupt request |

## Verification
A table of read commands is walked in both command bit orders. It reads each of the three registers, and it tells the plain decode apart from the reversed decode and each byte order from the others. Directed patterns cover the following cases:
- a select rise with the clock low, which must not start a transaction;
- select dropped in the middle of a command, which must not corrupt the next transaction;
- extra clock edges after a read has completed, which must not drive more data;
- writes to the calendar registers, which must be discarded;
- control writes with every bit set, which show that bit 7 stays read-only;
- the reset and interrupt command codes in both bit orders;
- a load of all ones, which shows each field mask.

// File: rtl/rtcs_pkg.sv
`timescale 1ns/1ps
package rtcs_pkg;
  localparam int PIN_W      = 4;
  localparam int SCK_B      = 0;
  localparam int SIO_B      = 1;
  localparam int CS_B       = 2;
  localparam int BYTE_W     = 8;
  localparam int BIT_IDX_W  = $clog2(BYTE_W);
  localparam int TOD_BYTES  = 7;
  localparam int TIME_OFS   = 4;
  localparam int TIME_BYTES = TOD_BYTES - TIME_OFS;
  localparam int BYTE_IDX_W = $clog2(TOD_BYTES + 1);
  localparam logic [3:0] PLAIN_NIB = 4'h6;

  typedef logic [BIT_IDX_W-1:0]  bit_idx_t;
  typedef logic [BYTE_IDX_W-1:0] byte_idx_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WR, ST_RD} state_e;
  typedef enum logic [1:0] {RK_NONE = 2'd0, RK_CTRL = 2'd1, RK_DT = 2'd2, RK_TM = 2'd3} kind_e;

  function automatic byte_idx_t last_byte(input kind_e k);
    case (k)
      RK_DT:   last_byte = byte_idx_t'(TOD_BYTES - 1);
      RK_TM:   last_byte = byte_idx_t'(TIME_BYTES - 1);
      default: last_byte = '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] bit_reverse(input logic [BYTE_W-1:0] b);
    for (int i = 0; i < BYTE_W; i++) bit_reverse[i] = b[BYTE_W-1-i];
  endfunction

  function automatic logic [BYTE_W-1:0] tod_mask(input int k);
    case (k)
      1:       tod_mask = 8'h1F;
      2:       tod_mask = 8'h3F;
      3:       tod_mask = 8'h07;
      4:       tod_mask = 8'h3F;
      5:       tod_mask = 8'h7F;
      6:       tod_mask = 8'h7F;
      default: tod_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] tod_init(input int k);
    case (k)
      0:       tod_init = 8'h01;
      1:       tod_init = 8'h06;
      2:       tod_init = 8'h13;
      3:       tod_init = 8'h03;
      4:       tod_init = 8'h23;
      default: tod_init = 8'h59;
    endcase
  endfunction
endpackage

// File: rtl/rtcs_pin_events.sv
`timescale 1ns/1ps
// Compares the stored pin value with the newly written one.
module rtcs_pin_events import rtcs_pkg::*; (
  input  logic [PIN_W-1:0] pin_old,
  input  logic [PIN_W-1:0] pin_new,
  output logic             start_cond,
  output logic             sck_rise,
  output logic             cs_high
);
  assign start_cond = pin_old[SCK_B] && !pin_old[CS_B] && pin_new[CS_B];
  assign sck_rise   = !pin_old[SCK_B] && pin_new[SCK_B];
  assign cs_high    = pin_new[CS_B];
endmodule

// File: rtl/rtcs_shifter.sv
`timescale 1ns/1ps
// Bit and byte position tracking plus the incoming byte buffer.
module rtcs_shifter import rtcs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              sin,
  output bit_idx_t          bit_idx,
  output byte_idx_t         byte_idx,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  logic [BYTE_W-2:0] acc_q, acc_d;
  bit_idx_t          bit_d;
  byte_idx_t         byte_d;

  assign byte_done = shift && (bit_idx == bit_idx_t'(BYTE_W - 1));
  assign byte_val  = {sin, acc_q};

  always_comb begin
    acc_d  = acc_q;
    bit_d  = bit_idx;
    byte_d = byte_idx;
    if (clr) begin
      acc_d  = '0;
      bit_d  = '0;
      byte_d = '0;
    end else if (shift) begin
      for (int k = 0; k < BYTE_W - 1; k++)
        if (bit_idx == bit_idx_t'(k)) acc_d[k] = sin;
      bit_d = bit_idx + 1'b1;
      if (byte_done) byte_d = byte_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else begin
      acc_q    <= acc_d;
      bit_idx  <= bit_d;
      byte_idx <= byte_d;
    end
  end
endmodule

// File: rtl/rtcs_regs.sv
`timescale 1ns/1ps
// Control register, calendar/time bytes and the outgoing byte selector.
module rtcs_regs import rtcs_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [BYTE_W-2:0]     ctrl_wdata,
  input  logic                  ctrl_clr,
  input  logic                  tod_load,
  input  logic [8*TOD_BYTES-1:0] tod_in,
  input  kind_e                 rd_kind,
  input  byte_idx_t             rd_idx,
  output logic [BYTE_W-1:0]     rd_data,
  output logic [BYTE_W-1:0]     ctrl_q
);
  logic [BYTE_W-1:0]      ctrl_d;
  logic [8*TOD_BYTES-1:0] tod_flat;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_clr)     ctrl_d = '0;
    else if (ctrl_we) ctrl_d = {ctrl_q[BYTE_W-1], ctrl_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar k = 0; k < TOD_BYTES; k++) begin : g_tod
    logic [BYTE_W-1:0] byte_q, byte_d;
    always_comb begin
      byte_d = byte_q;
      if (tod_load) byte_d = tod_in[8*k +: 8] & tod_mask(k);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= tod_init(k);
      else        byte_q <= byte_d;
    end
    assign tod_flat[8*k +: 8] = byte_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_kind)
      RK_CTRL: rd_data = ctrl_q;
      RK_DT:
        for (int k = 0; k < TOD_BYTES; k++)
          if (rd_idx == byte_idx_t'(k)) rd_data = tod_flat[8*k +: 8];
      RK_TM:
        for (int k = 0; k < TIME_BYTES; k++)
          if (rd_idx == byte_idx_t'(k)) rd_data = tod_flat[8*(k+TIME_OFS) +: 8];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_serial_slave.sv
`timescale 1ns/1ps
module rtc_serial_slave import rtcs_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin_we,
  input  logic [PIN_W-1:0]       pin_wdata,
  output logic [PIN_W-1:0]       pin_q,
  input  logic                   tod_load,
  input  logic [8*TOD_BYTES-1:0] tod_in,
  output logic [BYTE_W-1:0]      ctrl_q,
  output logic                   irq_pulse
);
  state_e            state_q, state_d;
  kind_e             kind_q, kind_d;
  logic [PIN_W-1:0]  pin_d;
  logic              irq_d;
  logic              start_cond, sck_rise, cs_high;
  logic              sh_clr, sh_shift, byte_done;
  bit_idx_t          bit_idx;
  byte_idx_t         byte_idx;
  logic [BYTE_W-1:0] byte_val, cmd, rd_data;
  logic              ctrl_we, ctrl_clr;

  rtcs_pin_events u_ev (
    .pin_old(pin_q), .pin_new(pin_wdata),
    .start_cond(start_cond), .sck_rise(sck_rise), .cs_high(cs_high)
  );

  rtcs_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift(sh_shift),
    .sin(pin_wdata[SIO_B]), .bit_idx(bit_idx), .byte_idx(byte_idx),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  rtcs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(byte_val[BYTE_W-2:0]),
    .ctrl_clr(ctrl_clr), .tod_load(tod_load), .tod_in(tod_in),
    .rd_kind(kind_q), .rd_idx(byte_idx), .rd_data(rd_data), .ctrl_q(ctrl_q)
  );

  // Either arrival order yields the same command.
  assign cmd = (byte_val[BYTE_W-1 -: 4] == PLAIN_NIB) ? byte_val : bit_reverse(byte_val);

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    pin_d    = pin_q;
    irq_d    = 1'b0;
    sh_clr   = 1'b0;
    sh_shift = 1'b0;
    ctrl_we  = 1'b0;
    ctrl_clr = 1'b0;
    if (pin_we) begin
      pin_d = pin_wdata;
      if (state_q == ST_IDLE) begin
        if (start_cond) begin
          state_d = ST_CMD;
          sh_clr  = 1'b1;
        end
      end else if (!cs_high) begin
        state_d = ST_IDLE;
        kind_d  = RK_NONE;
        sh_clr  = 1'b1;
      end else if (sck_rise) begin
        sh_shift = 1'b1;
        if (state_q == ST_RD) pin_d[SIO_B] = rd_data[bit_idx];
        if (byte_done) begin
          case (state_q)
            ST_CMD: begin
              sh_clr  = 1'b1;
              state_d = ST_IDLE;
              kind_d  = RK_NONE;
              if (!cmd[0]) begin
                case (cmd[3:1])
                  3'd0: ctrl_clr = 1'b1;
                  3'd1: begin state_d = ST_WR; kind_d = RK_CTRL; end
                  3'd2: begin state_d = ST_WR; kind_d = RK_DT;   end
                  3'd3: begin state_d = ST_WR; kind_d = RK_TM;   end
                  3'd6: irq_d = 1'b1;
                  default: ;
                endcase
              end else begin
                case (cmd[3:1])
                  3'd1: begin state_d = ST_RD; kind_d = RK_CTRL; end
                  3'd2: begin state_d = ST_RD; kind_d = RK_DT;   end
                  3'd3: begin state_d = ST_RD; kind_d = RK_TM;   end
                  default: ;
                endcase
              end
            end
            ST_WR, ST_RD: begin
              if (state_q == ST_WR && kind_q == RK_CTRL && byte_idx == '0) ctrl_we = 1'b1;
              if (byte_idx == last_byte(kind_q)) begin
                state_d = ST_IDLE;
                kind_d  = RK_NONE;
                sh_clr  = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= RK_NONE;
      pin_q     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      pin_q     <= pin_d;
      irq_pulse <= irq_d;
    end
  end
endmodule

// File: rtl/rtc_serial_slave_chk.sv
`timescale 1ns/1ps
module rtc_serial_slave_chk import rtcs_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_we,
  input logic [PIN_W-1:0]  pin_wdata,
  input logic [PIN_W-1:0]  pin_q,
  input logic [BYTE_W-1:0] ctrl_q,
  input logic              irq_pulse,
  input state_e            state_q
);
  p_pin_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_we |=> $stable(pin_q));
  p_pin_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_we |=> (pin_q[CS_B] == $past(pin_wdata[CS_B])) && (pin_q[SCK_B] == $past(pin_wdata[SCK_B])));
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pin_we && pin_q[SCK_B] && !pin_q[CS_B] && pin_wdata[CS_B]) |=> state_q == ST_CMD);
  p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pin_we && !pin_q[SCK_B]) |=> state_q == ST_IDLE);
  p_ctrl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_we |=> $stable(ctrl_q));
  p_ctrl_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctrl_q[BYTE_W-1]));
  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(pin_we) && $past(state_q) == ST_CMD));
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && pin_we && !pin_wdata[CS_B]) |=> state_q == ST_IDLE);
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (.*);

// File: tb/rtc_serial_slave_bench.sv
`timescale 1ns/1ps
module rtc_serial_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_we = 1'b0;
  logic [3:0]  pin_wdata = 4'h0;
  logic        tod_load = 1'b0;
  logic [55:0] tod_in = '0;
  logic [3:0]  pin_q;
  logic [7:0]  ctrl_q;
  logic        irq_pulse;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [55:0] DEF_DT = 56'h59_59_23_03_13_06_01;
  localparam logic [55:0] DEF_TM = 56'h59_59_23;

  typedef struct packed {
    logic [7:0]  raw;
    logic [3:0]  n;
    logic [55:0] exp;
  } rvec_t;

  // raw = byte as it arrives LSB-first position; 0xA6/0xE6/0xC6 are reversed forms
  localparam rvec_t RVEC [6] = '{
    '{8'h65, 4'd7, DEF_DT},
    '{8'hA6, 4'd7, DEF_DT},
    '{8'h67, 4'd3, DEF_TM},
    '{8'hE6, 4'd3, DEF_TM},
    '{8'h63, 4'd1, 56'h0},
    '{8'hC6, 4'd1, 56'h0}
  };

  rtc_serial_slave u_rtc_serial_slave (
    .clk(clk), .rst_n(rst_n), .pin_we(pin_we), .pin_wdata(pin_wdata), .pin_q(pin_q),
    .tod_load(tod_load), .tod_in(tod_in), .ctrl_q(ctrl_q), .irq_pulse(irq_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_pins(input logic [3:0] v);
    @(negedge clk);
    pin_we = 1'b1;
    pin_wdata = v;
    @(negedge clk);
    pin_we = 1'b0;
  endtask

  task automatic start_xfer();
    drive_pins(4'b0001);
    drive_pins(4'b0101);
  endtask

  task automatic stop_xfer();
    drive_pins(4'b0001);
  endtask

  task automatic send_bit(input logic b);
    drive_pins({2'b01, b, 1'b0});
    drive_pins({2'b01, b, 1'b1});
  endtask

  task automatic send_byte(input logic [7:0] x);
    for (int i = 0; i < 8; i++) send_bit(x[i]);
  endtask

  task automatic recv_byte(output logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      drive_pins(4'b0100);
      drive_pins(4'b0101);
      r[i] = pin_q[1];
    end
  endtask

  task automatic read_bytes(input logic [7:0] raw, input int n, output logic [55:0] r);
    logic [7:0] b;
    r = '0;
    start_xfer();
    send_byte(raw);
    for (int i = 0; i < n; i++) begin
      recv_byte(b);
      r[8*i +: 8] = b;
    end
    stop_xfer();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] r;
    repeat (4) @(negedge clk);
    chk("R1 pin_q reset", 64'(pin_q), 64'h0);
    chk("R1 ctrl_q reset", 64'(ctrl_q), 64'h0);
    chk("R1 irq reset", 64'(irq_pulse), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 store and hold
    drive_pins(4'hA);
    chk("R2 store", 64'(pin_q), 64'hA);
    repeat (3) @(negedge clk);
    chk("R2 hold", 64'(pin_q), 64'hA);

    // R4 R5 R6 R12 table of reads in both bit orders
    for (int v = 0; v < 6; v++) begin
      start_xfer();
      send_byte(RVEC[v].raw);
      for (int k = 0; k < int'(RVEC[v].n); k++) begin
        recv_byte(b);
        chk($sformatf("R4 R5 R6 R12 vec%0d byte%0d", v, k), 64'(b), 64'(RVEC[v].exp[8*k +: 8]));
      end
      stop_xfer();
    end

    // R7 control write keeps bit 7
    start_xfer(); send_byte(8'h62); send_byte(8'hFF); stop_xfer();
    chk("R7 ctrl all ones", 64'(ctrl_q), 64'h7F);
    read_bytes(8'hC6, 1, r);
    chk("R7 ctrl readback", 64'(r), 64'h7F);
    start_xfer(); send_byte(8'h46); send_byte(8'h55); stop_xfer();
    chk("R7 ctrl reversed cmd", 64'(ctrl_q), 64'h55);

    // R6 idle after last read bit
    start_xfer(); send_byte(8'h63); recv_byte(b);
    chk("R6 ctrl read", 64'(b), 64'h55);
    drive_pins(4'b0100); drive_pins(4'b0101);
    chk("R6 no drive after end", 64'(pin_q[1]), 64'h0);
    stop_xfer();

    // R8 calendar writes discarded
    start_xfer(); send_byte(8'h64);
    for (int i = 0; i < 7; i++) send_byte(8'h00);
    stop_xfer();
    read_bytes(8'h65, 7, r);
    chk("R8 date-time unchanged", 64'(r), 64'(DEF_DT));
    start_xfer(); send_byte(8'h66);
    for (int i = 0; i < 3; i++) send_byte(8'h00);
    stop_xfer();
    read_bytes(8'h67, 3, r);
    chk("R8 time unchanged", 64'(r), 64'(DEF_TM));
    chk("R8 ctrl unchanged", 64'(ctrl_q), 64'h55);

    // R3 select rise with clock low is not a start
    drive_pins(4'b0000);
    drive_pins(4'b0100);
    send_byte(8'h63);
    recv_byte(b);
    chk("R3 no false start", 64'(b), 64'h0);
    stop_xfer();

    // R11 abort mid-command
    start_xfer();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    stop_xfer();
    read_bytes(8'h63, 1, r);
    chk("R11 clean after abort", 64'(r), 64'h55);

    // R9 reset command
    start_xfer(); send_byte(8'h60);
    chk("R9 no irq", 64'(irq_pulse), 64'h0);
    stop_xfer();
    chk("R9 ctrl cleared", 64'(ctrl_q), 64'h0);

    // R10 interrupt command, both orders
    start_xfer(); send_byte(8'h36);
    chk("R10 irq high", 64'(irq_pulse), 64'h1);
    @(negedge clk);
    chk("R10 irq one cycle", 64'(irq_pulse), 64'h0);
    stop_xfer();
    start_xfer(); send_byte(8'h6C);
    chk("R10 irq plain order", 64'(irq_pulse), 64'h1);
    stop_xfer();

    // R12 load with masking
    @(negedge clk);
    tod_load = 1'b1;
    tod_in = {56{1'b1}};
    @(negedge clk);
    tod_load = 1'b0;
    read_bytes(8'h65, 7, r);
    chk("R12 masked load", 64'(r), 64'h7F7F3F073F1FFF);
    read_bytes(8'h67, 3, r);
    chk("R12 time bytes", 64'(r), 64'h7F7F3F);

    report();
  end
endmodule